// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block lets a two-wire (I2C-compatible) bus master reach a small set of temperature-monitor registers. A system clock much faster than SCL samples both bus lines. The block sees START, repeated START and STOP. It accepts bus address `1001` followed by three strap inputs, acknowledges bytes, and pulls SDA low through an open-drain output enable. A 2-bit pointer selects one of four registers. The first data byte of a write sets the pointer, and any later bytes of that write go into the selected register. A read returns the selected register starting at the pointer's current value.

The registers have different widths. The temperature register is 16 bits and read-only. The configuration register is 8 bits. The hysteresis and over-limit thresholds are 16 bits each. A converter port delivers 9-bit two's-complement temperature words. While a read is in progress, a newly arrived word is parked and is applied once the read ends, so the two bytes of one read always belong to the same sample. A one-cycle strobe marks every register byte that is shifted out, for the alarm logic next to this block.

Top module: `tsense_i2c_regs`

## Requirements
- R1: After reset, the pointer selects temperature (00), the configuration reads 0x00, hysteresis reads 0x4B00, the over-limit reads 0x5000, temperature reads 0x0000, and SDA is released (sda_oe_o low).
- R2: Only the address byte whose upper seven bits are 1001 followed by strap_i[2:0] is acknowledged; bit 0 of that byte is 1 for read. Any other address gets no acknowledge.
- R3: A pointer byte with any of bits 7:2 set gets no acknowledge. The rest of the transfer is ignored, and the pointer and all registers keep their values.
- R4: Pointer bits 1:0 select 00 temperature, 01 configuration, 10 hysteresis, 11 over-limit. The pointer persists across transactions, so a read without a pointer write returns the register selected last.
- R5: 16-bit registers are written as pointer, high byte, low byte, and read high byte first. Every byte of a write is acknowledged, and the new value appears on hyst_o or limit_o.
- R6: A configuration write takes one data byte. Bits 4:0 are stored, and bits 7:5 always read as zero.
- R7: A converter word conv_temp_i[8:0] appears in temperature bits 15:7, and bits 6:0 read zero. Data written while the pointer is 00 leaves the temperature register unchanged.
- R8: A converter word that arrives while a read transaction is open does not change temp_o, and the read returns the earlier value. The parked word is applied on the first clock after the read ends by NACK, STOP or START.
- R9: rd_strobe_o is high for exactly one clock per byte loaded for transmission, and only inside a read transaction.
- R10: After the master NACKs a read byte, or on any STOP, the slave releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| strap_i | input | 3 | Low three bits of the bus address |
| conv_valid_i | input | 1 | One-cycle pulse: new converter word |
| conv_temp_i | input | 9 | Converter word, two's complement, half-degree steps |
| rd_strobe_o | output | 1 | Pulse per register byte shifted out |
| cfg_o | output | 8 | Configuration register |
| hyst_o | output | 16 | Hysteresis threshold register |
| limit_o | output | 16 | Over-limit threshold register |
| temp_o | output | 16 | Temperature register |

## Verification
The hardest case to reach is a converter word arriving in the middle of a two-byte temperature read. The bench gets there by driving the bus byte by byte. It takes the high byte with an ACK, pulses the converter port before clocking the low byte, and checks that temp_o does not move. It then checks that the low byte still belongs to the old sample and that the new word shows up right after the master's NACK. Illegal pointer bytes and foreign addresses are sent in the middle of a session, and the bench checks that the stored values stay the same.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_RX,
        BS_ACKW,
        BS_ACK,
        BS_TX,
        BS_TXACK,
        BS_TXACKW
    } bus_st_e;

    localparam logic [1:0] PTR_TEMP = 2'b00;
    localparam logic [1:0] PTR_CFG  = 2'b01;
    localparam logic [1:0] PTR_HYST = 2'b10;
    localparam logic [1:0] PTR_LIM  = 2'b11;

    typedef struct packed {
        bus_st_e     st;
        logic [2:0]  cnt;
        logic [7:0]  sh;
        logic [2:0]  bidx;
        logic        rw;
        logic        oe;
        logic        busy;
        logic        strobe;
        logic        lo;
    } fsm_t;

endpackage

// File: rtl/tsi_line_sync.sv
module tsi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_p;
        logic [STAGES-1:0] sda_p;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;
    logic  scl_s, sda_s;

    assign scl_s = q.scl_p[STAGES-1];
    assign sda_s = q.sda_p[STAGES-1];

    always_comb begin
        d          = q;
        d.scl_p    = {q.scl_p[STAGES-2:0], scl_i};
        d.sda_p    = {q.sda_p[STAGES-2:0], sda_i};
        d.scl_prev = scl_s;
        d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_o   = sda_s;
    assign start_o = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_o  = scl_s & q.scl_prev & ~q.sda_prev & sda_s;
    assign rise_o  = scl_s & ~q.scl_prev;
    assign fall_o  = ~scl_s & q.scl_prev;
endmodule

// File: rtl/tsi_regs.sv
module tsi_regs
    import tsi_pkg::*;
#(
    parameter int          TEMP_W   = 9,
    parameter logic [15:0] HYST_RST = 16'h4B00,
    parameter logic [15:0] LIM_RST  = 16'h5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic [1:0]        ptr_val,
    input  logic              dat_we,
    input  logic              dat_second,
    input  logic [7:0]        dat_val,
    input  logic              rd_lo,
    input  logic              busy,
    input  logic              conv_valid,
    input  logic [TEMP_W-1:0] conv_temp,
    output logic [7:0]        rd_byte,
    output logic [7:0]        cfg_o,
    output logic [15:0]       hyst_o,
    output logic [15:0]       limit_o,
    output logic [15:0]       temp_o
);
    localparam int CFG_W = 5;
    localparam int PAD_W = 16 - TEMP_W;

    typedef struct packed {
        logic [1:0]        ptr;
        logic [CFG_W-1:0]  cfg;
        logic [15:0]       hyst;
        logic [15:0]       lim;
        logic [7:0]        stage;
        logic [15:0]       temp;
        logic [TEMP_W-1:0] pend;
        logic              pend_v;
    } regs_t;

    regs_t q, d;
    logic [15:0] sel16;

    always_comb begin
        d = q;
        if (ptr_we) d.ptr = ptr_val;
        if (dat_we) begin
            case (q.ptr)
                PTR_CFG:  if (!dat_second) d.cfg = dat_val[CFG_W-1:0];
                PTR_HYST: if (!dat_second) d.stage = dat_val;
                          else d.hyst = {q.stage, dat_val};
                PTR_LIM:  if (!dat_second) d.stage = dat_val;
                          else d.lim = {q.stage, dat_val};
                default:  ;
            endcase
        end
        if (conv_valid) begin
            if (busy) begin
                d.pend   = conv_temp;
                d.pend_v = 1'b1;
            end else begin
                d.temp   = {conv_temp, {PAD_W{1'b0}}};
                d.pend_v = 1'b0;
            end
        end else if (q.pend_v && !busy) begin
            d.temp   = {q.pend, {PAD_W{1'b0}}};
            d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.hyst <= HYST_RST;
            q.lim  <= LIM_RST;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.ptr)
            PTR_HYST: sel16 = q.hyst;
            PTR_LIM:  sel16 = q.lim;
            default:  sel16 = q.temp;
        endcase
        if (q.ptr == PTR_CFG) rd_byte = cfg_o;
        else                  rd_byte = rd_lo ? sel16[7:0] : sel16[15:8];
    end

    assign cfg_o   = {{(8-CFG_W){1'b0}}, q.cfg};
    assign hyst_o  = q.hyst;
    assign limit_o = q.lim;
    assign temp_o  = q.temp;
endmodule

// File: rtl/tsi_bus_fsm.sv
module tsi_bus_fsm
    import tsi_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b1001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] strap,
    input  logic       sda_s,
    input  logic       start,
    input  logic       stop,
    input  logic       rise,
    input  logic       fall,
    input  logic [7:0] rd_byte,
    output logic       sda_oe,
    output logic       busy,
    output logic       strobe,
    output logic       rd_lo,
    output logic       ptr_we,
    output logic [1:0] ptr_val,
    output logic       dat_we,
    output logic       dat_second,
    output logic [7:0] dat_val
);
    localparam logic [2:0] BIDX_MAX = 3'd4;

    fsm_t q, d;
    logic [7:0] rx_byte;

    assign rx_byte = {q.sh[6:0], sda_s};

    always_comb begin
        d          = q;
        d.strobe   = 1'b0;
        ptr_we     = 1'b0;
        dat_we     = 1'b0;
        ptr_val    = rx_byte[1:0];
        dat_val    = rx_byte;
        dat_second = (q.bidx == 3'd3);
        if (start) begin
            d.st   = BS_RX;
            d.cnt  = '0;
            d.bidx = '0;
            d.oe   = 1'b0;
            d.busy = 1'b0;
            d.rw   = 1'b0;
        end else if (stop) begin
            d.st   = BS_IDLE;
            d.oe   = 1'b0;
            d.busy = 1'b0;
        end else begin
            case (q.st)
                BS_RX: if (rise) begin
                    d.sh  = rx_byte;
                    d.cnt = q.cnt + 3'd1;
                    if (q.cnt == 3'd7) begin
                        if (q.bidx == 3'd0) begin
                            if (rx_byte[7:1] == {ADDR_HI, strap}) begin
                                d.rw   = rx_byte[0];
                                d.busy = rx_byte[0];
                                d.lo   = 1'b0;
                                d.st   = BS_ACKW;
                            end else begin
                                d.st = BS_IDLE;
                            end
                        end else if (q.bidx == 3'd1) begin
                            if (rx_byte[7:2] == 6'd0) begin
                                ptr_we = 1'b1;
                                d.st   = BS_ACKW;
                            end else begin
                                d.st = BS_IDLE;
                            end
                        end else begin
                            dat_we = (q.bidx < BIDX_MAX);
                            d.st   = BS_ACKW;
                        end
                    end
                end
                BS_ACKW: if (fall) begin
                    d.oe = 1'b1;
                    d.st = BS_ACK;
                end
                BS_ACK: if (fall) begin
                    if (q.rw) begin
                        d.st     = BS_TX;
                        d.cnt    = '0;
                        d.sh     = rd_byte;
                        d.oe     = ~rd_byte[7];
                        d.strobe = 1'b1;
                        d.lo     = ~q.lo;
                    end else begin
                        d.oe   = 1'b0;
                        d.st   = BS_RX;
                        d.cnt  = '0;
                        d.bidx = (q.bidx == BIDX_MAX) ? BIDX_MAX : q.bidx + 3'd1;
                    end
                end
                BS_TX: if (fall) begin
                    if (q.cnt == 3'd7) begin
                        d.oe = 1'b0;
                        d.st = BS_TXACK;
                    end else begin
                        d.cnt = q.cnt + 3'd1;
                        d.sh  = {q.sh[6:0], 1'b0};
                        d.oe  = ~q.sh[6];
                    end
                end
                BS_TXACK: if (rise) begin
                    if (!sda_s) begin
                        d.st = BS_TXACKW;
                    end else begin
                        d.st   = BS_IDLE;
                        d.busy = 1'b0;
                    end
                end
                BS_TXACKW: if (fall) begin
                    d.st     = BS_TX;
                    d.cnt    = '0;
                    d.sh     = rd_byte;
                    d.oe     = ~rd_byte[7];
                    d.strobe = 1'b1;
                    d.lo     = ~q.lo;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe = q.oe;
    assign busy   = q.busy;
    assign strobe = q.strobe;
    assign rd_lo  = q.lo;
endmodule

// File: rtl/tsense_i2c_regs.sv
module tsense_i2c_regs
    import tsi_pkg::*;
#(
    parameter int          TEMP_W      = 9,
    parameter int          SYNC_STAGES = 2,
    parameter logic [3:0]  ADDR_HI     = 4'b1001,
    parameter logic [15:0] HYST_RST    = 16'h4B00,
    parameter logic [15:0] LIM_RST     = 16'h5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        strap_i,
    input  logic              conv_valid_i,
    input  logic [TEMP_W-1:0] conv_temp_i,
    output logic              rd_strobe_o,
    output logic [7:0]        cfg_o,
    output logic [15:0]       hyst_o,
    output logic [15:0]       limit_o,
    output logic [15:0]       temp_o
);
    logic       sda_s, start_evt, stop_evt, scl_rise, scl_fall;
    logic       read_busy, rd_lo, ptr_we, dat_we, dat_second;
    logic [1:0] ptr_val;
    logic [7:0] dat_val, rd_byte;

    tsi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .start_o(start_evt), .stop_o(stop_evt),
        .rise_o(scl_rise), .fall_o(scl_fall)
    );

    tsi_bus_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
        .clk(clk), .rst_n(rst_n), .strap(strap_i), .sda_s(sda_s),
        .start(start_evt), .stop(stop_evt), .rise(scl_rise), .fall(scl_fall),
        .rd_byte(rd_byte), .sda_oe(sda_oe_o), .busy(read_busy),
        .strobe(rd_strobe_o), .rd_lo(rd_lo), .ptr_we(ptr_we),
        .ptr_val(ptr_val), .dat_we(dat_we), .dat_second(dat_second),
        .dat_val(dat_val)
    );

    tsi_regs #(.TEMP_W(TEMP_W), .HYST_RST(HYST_RST), .LIM_RST(LIM_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_val(ptr_val),
        .dat_we(dat_we), .dat_second(dat_second), .dat_val(dat_val),
        .rd_lo(rd_lo), .busy(read_busy), .conv_valid(conv_valid_i),
        .conv_temp(conv_temp_i), .rd_byte(rd_byte), .cfg_o(cfg_o),
        .hyst_o(hyst_o), .limit_o(limit_o), .temp_o(temp_o)
    );
endmodule

// File: rtl/tsense_i2c_regs_chk.sv
module tsense_i2c_regs_chk #(
    parameter int TW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          read_busy,
    input logic          stop_evt,
    input logic          sda_oe,
    input logic          rd_strobe,
    input logic          conv_valid,
    input logic [TW-1:0] conv_temp,
    input logic [15:0]   temp
);
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (read_busy && $past(read_busy)) |-> $stable(temp));

    // R8
    idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && !read_busy) |=> (temp[15:16-TW] == $past(conv_temp)));

    // R9
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rd_strobe);

    // R9
    strobe_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> read_busy);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);
endmodule

bind tsense_i2c_regs tsense_i2c_regs_chk #(.TW(TEMP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .read_busy(read_busy), .stop_evt(stop_evt),
    .sda_oe(sda_oe_o), .rd_strobe(rd_strobe_o), .conv_valid(conv_valid_i),
    .conv_temp(conv_temp_i), .temp(temp_o)
);

// File: tb/tsense_i2c_regs_test.sv
module tsense_i2c_regs_test;
    localparam int Q = 10;

    typedef struct packed {
        logic [1:0]  ptr;
        logic        wide;
        logic [15:0] wdat;
        logic [15:0] rexp;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'b01, 1'b0, 16'h00FF, 16'h001F},
        '{2'b10, 1'b1, 16'h1234, 16'h1234},
        '{2'b11, 1'b1, 16'hFF80, 16'hFF80},
        '{2'b01, 1'b0, 16'h0016, 16'h0016},
        '{2'b10, 1'b1, 16'hE700, 16'hE700}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'b010;
    logic        conv_valid = 1'b0;
    logic [8:0]  conv_temp = '0;
    logic        sda_oe, rd_strobe;
    logic [7:0]  cfg;
    logic [15:0] hyst, lim, temp;
    logic        sda_line;

    assign sda_line = sda_m & ~sda_oe;

    tsense_i2c_regs uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .strap_i(strap), .conv_valid_i(conv_valid),
        .conv_temp_i(conv_temp), .rd_strobe_o(rd_strobe), .cfg_o(cfg),
        .hyst_o(hyst), .limit_o(lim), .temp_o(temp)
    );

    int checks = 0;
    int errors = 0;
    int strobes = 0;

    always @(negedge clk) if (rd_strobe) strobes++;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0;
        end
        tick(Q);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_m = 1'b0;
        end
        tick(Q);
        sda_m = ~give_ack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0;
        tick(Q);
    endtask

    function automatic logic [7:0] dev(input logic rd);
        return {4'b1001, strap, rd};
    endfunction

    task automatic write_reg(input logic [1:0] p, input int n, input logic [15:0] v, output logic all_ack);
        logic a;
        all_ack = 1'b1;
        bus_start();
        send_byte(dev(1'b0), a); all_ack &= a;
        send_byte({6'd0, p}, a); all_ack &= a;
        if (n == 1) begin
            send_byte(v[7:0], a); all_ack &= a;
        end else if (n == 2) begin
            send_byte(v[15:8], a); all_ack &= a;
            send_byte(v[7:0], a); all_ack &= a;
        end
        bus_stop();
    endtask

    task automatic read_reg(input logic setp, input logic [1:0] p, input int n, output logic [15:0] v);
        logic a;
        logic [7:0] hi, lo;
        bus_start();
        if (setp) begin
            send_byte(dev(1'b0), a);
            send_byte({6'd0, p}, a);
            bus_start();
        end
        send_byte(dev(1'b1), a);
        if (n == 2) begin
            recv_byte(1'b1, hi);
            recv_byte(1'b0, lo);
            v = {hi, lo};
        end else begin
            recv_byte(1'b0, lo);
            v = {8'h00, lo};
        end
        bus_stop();
    endtask

    task automatic conv_pulse(input logic [8:0] t);
        conv_temp = t; conv_valid = 1'b1; tick(1);
        conv_valid = 1'b0; tick(1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        tick(150000);
        errors++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] rv;
        logic        ok, a;
        logic [7:0]  hi, lo;
        int          s0;

        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset values
        chk("R1 cfg", {8'h00, cfg}, 16'h0000);
        chk("R1 hyst", hyst, 16'h4B00);
        chk("R1 limit", lim, 16'h5000);
        chk("R1 temp", temp, 16'h0000);
        chk("R1 sda released", {15'd0, sda_oe}, 16'd0);
        read_reg(1'b0, 2'b00, 2, rv);
        chk("R1 R4 default pointer reads temp", rv, 16'h0000);
        read_reg(1'b1, 2'b10, 2, rv);
        chk("R1 hyst over bus", rv, 16'h4B00);
        read_reg(1'b1, 2'b11, 2, rv);
        chk("R1 limit over bus", rv, 16'h5000);

        // R5 R6 R4 R9 table walk
        foreach (VECS[k]) begin
            write_reg(VECS[k].ptr, VECS[k].wide ? 2 : 1, VECS[k].wdat, ok);
            chk("R5 write acked", {15'd0, ok}, 16'd1);
            s0 = strobes;
            read_reg(1'b0, 2'b00, VECS[k].wide ? 2 : 1, rv);
            chk("R4 R5 R6 preset-pointer readback", rv, VECS[k].rexp);
            chk("R9 strobes per read", 16'(strobes - s0), VECS[k].wide ? 16'd2 : 16'd1);
            case (VECS[k].ptr)
                2'b01:   chk("R6 cfg port", {8'h00, cfg}, VECS[k].rexp);
                2'b10:   chk("R5 hyst port", hyst, VECS[k].rexp);
                default: chk("R5 limit port", lim, VECS[k].rexp);
            endcase
        end

        // R7 converter placement, positive and negative
        conv_pulse(9'h032);
        tick(2);
        chk("R7 temp +25", temp, 16'h1900);
        conv_pulse(9'h1CE);
        tick(2);
        chk("R7 temp -25", temp, 16'hE700);
        read_reg(1'b1, 2'b00, 2, rv);
        chk("R7 temp over bus", rv, 16'hE700);

        // R7 data written to temperature pointer ignored
        write_reg(2'b00, 2, 16'hAAAA, ok);
        chk("R7 temp write ignored", temp, 16'hE700);
        read_reg(1'b0, 2'b00, 2, rv);
        chk("R7 temp readback after write", rv, 16'hE700);

        // R2 foreign addresses
        bus_start();
        send_byte({4'b1001, strap ^ 3'b001, 1'b0}, a);
        bus_stop();
        chk("R2 wrong strap no ack", {15'd0, a}, 16'd0);
        bus_start();
        send_byte({4'b1011, strap, 1'b1}, a);
        bus_stop();
        chk("R2 wrong prefix no ack", {15'd0, a}, 16'd0);
        chk("R2 sda released", {15'd0, sda_oe}, 16'd0);

        // R3 illegal pointer byte (bit 2 set) then stray data
        write_reg(2'b10, 0, 16'h0000, ok);
        bus_start();
        send_byte(dev(1'b0), a);
        send_byte(8'h07, a);
        chk("R3 illegal pointer not acked", {15'd0, a}, 16'd0);
        send_byte(8'h55, a);
        chk("R3 later byte not acked", {15'd0, a}, 16'd0);
        bus_stop();
        chk("R3 limit unchanged", lim, 16'hFF80);
        chk("R3 hyst unchanged", hyst, 16'hE700);
        read_reg(1'b0, 2'b00, 2, rv);
        chk("R3 pointer kept at hysteresis", rv, 16'hE700);

        // R8 R10 converter word during an open read
        write_reg(2'b00, 0, 16'h0000, ok);
        bus_start();
        send_byte(dev(1'b1), a);
        recv_byte(1'b1, hi);
        conv_pulse(9'h0FA);
        tick(3);
        chk("R8 temp held during read", temp, 16'hE700);
        recv_byte(1'b0, lo);
        chk("R8 read returns earlier sample", {hi, lo}, 16'hE700);
        chk("R10 sda released after NACK", {15'd0, sda_oe}, 16'd0);
        chk("R8 parked word applied after NACK", temp, 16'h7D00);
        bus_stop();
        chk("R10 sda released after STOP", {15'd0, sda_oe}, 16'd0);
        read_reg(1'b0, 2'b00, 2, rv);
        chk("R8 new word over bus", rv, 16'h7D00);

        finish_run();
    end
endmodule